// File: doc/BRIEF.md
# Loop Counter Test-and-Branch Unit

This block runs the loop-closing primitive of a 16-bit core. A single control byte tells it whether to count a register down, count it up, or only examine it. It also says which register is the counter, whether to branch on zero or on non-zero, and the sign of the displacement. The unit reads the chosen register through a combinational read port. It works out the counter's new value and decides whether the loop branch is taken. It also forms the branch target from the program counter, which already points past the instruction.

Each start pulse handles one instruction. All results appear, registered, on the clock edge after the pulse. The counter can be an 8-bit register (the two accumulators or the condition-code byte) or a 16-bit one (the double accumulator, the two index registers, the stack pointer). The unit handles the width: it wraps the count and tests for zero at that register's own size. Instruction fetch and register storage are outside the block. The core applies the writeback port to its register file.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done_o`, `taken_o`, `wb_en_o` are 0 and `target_o`, `wb_sel_o`, `wb_data_o` are all zero.
- R2: `done_o` is 1 exactly in the cycle after a cycle with `start_i` high. In a cycle after no start, every output is zero.
- R3: Control bits 7:6 pick the operation: 2'b10 adds one, 2'b01 only tests, 2'b00 and 2'b11 subtract one. Both counts wrap modulo the register width.
- R4: Control bits 2:0 are presented on `rf_sel_o` in the same cycle. Selectors 0, 1, 2 are 8-bit registers: only `rf_data_i[7:0]` is used, and the written value has bits 15:8 at zero. Selectors 4 to 7 are 16-bit registers.
- R5: Control bit 5 set means the branch is taken when the resulting counter value is non-zero. Bit 5 clear means it is taken when the value is zero.
- R6: `target_o` = `pc_i` plus the 9-bit two's-complement displacement {control bit 4, offset byte}, modulo 2^16. It is given whenever `done_o` is 1.
- R7: For count operations on a valid selector, `wb_en_o` is 1 whether or not the branch is taken. `wb_sel_o` then equals control bits 2:0 and `wb_data_o` carries the new value.
- R8: The test operation writes nothing back (`wb_en_o` 0, `wb_sel_o` and `wb_data_o` zero). It branches on the value as read.
- R9: For 8-bit registers the zero test looks only at the low byte, so a read value of 16'h3400 counts as zero.
- R10: Selector 3 is reserved. It gives no writeback and the branch is never taken, but `done_o` and `target_o` still follow R2 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One instruction to process this cycle |
| postbyte_i | input | 8 | Control byte: operation, sense, offset sign, selector |
| offset_i | input | 8 | Low eight bits of the branch displacement |
| pc_i | input | 16 | Program counter past the instruction |
| rf_sel_o | output | 3 | Register file read select |
| rf_data_i | input | 16 | Register file read data for `rf_sel_o` |
| done_o | output | 1 | Result valid |
| taken_o | output | 1 | Loop branch taken |
| target_o | output | 16 | Branch target address |
| wb_en_o | output | 1 | Counter writeback enable |
| wb_sel_o | output | 3 | Counter writeback register select |
| wb_data_o | output | 16 | Counter writeback value |

## Verification
The properties assume that `rf_data_i` answers `rf_sel_o` in the same cycle and that `start_i` is low while reset is asserted. The past-sampled checks compare against the inputs of the start cycle. The bench keeps its register model combinational, driven from `rf_sel_o`, and holds `start_i` low through reset. It mixes directed cases with random control bytes and register contents. These cover every selector, including the reserved one, all four operation codes, and both offset signs.

// File: rtl/loop_br_pkg.sv
package loop_br_pkg;

    localparam int LB_DATA_W   = 16;
    localparam int LB_NARROW_W = 8;
    localparam int LB_SEL_W    = 3;
    localparam int LB_OFF_W    = 8;

    typedef enum logic [1:0] {
        OP_DEC     = 2'b00,
        OP_TEST    = 2'b01,
        OP_INC     = 2'b10,
        OP_DEC_ALT = 2'b11
    } loop_op_e;

endpackage

// File: rtl/loop_count_alu.sv
module loop_count_alu
    import loop_br_pkg::*;
#(
    parameter int DATA_W      = LB_DATA_W,
    parameter int NARROW_W    = LB_NARROW_W,
    parameter int SEL_W       = LB_SEL_W,
    parameter int NARROW_SELS = 3,
    parameter int RSVD_SEL    = 3
) (
    input  loop_op_e           op_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic [DATA_W-1:0]  nxt_o,
    output logic               zero_o,
    output logic               rsvd_o,
    output logic               wb_ok_o
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic              narrow;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        narrow = (int'(sel_i) < NARROW_SELS);
        rsvd_o = (int'(sel_i) == RSVD_SEL);
        cur    = narrow ? {{PAD_W{1'b0}}, rd_data_i[NARROW_W-1:0]} : rd_data_i;
        case (op_i)
            OP_INC:  nxt = cur + DATA_W'(1);
            OP_TEST: nxt = cur;
            default: nxt = cur - DATA_W'(1);
        endcase
        if (narrow) begin
            nxt[DATA_W-1:NARROW_W] = '0;
        end
        nxt_o   = nxt;
        zero_o  = (nxt == '0);
        wb_ok_o = !rsvd_o && (op_i != OP_TEST);
    end

endmodule

// File: rtl/loop_target_add.sv
module loop_target_add
    import loop_br_pkg::*;
#(
    parameter int ADDR_W = LB_DATA_W,
    parameter int OFF_W  = LB_OFF_W
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              sign_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] disp;

    always_comb begin
        disp     = {{EXT_W{sign_i}}, off_i};
        target_o = pc_i + disp;
    end

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import loop_br_pkg::*;
#(
    parameter int DATA_W   = LB_DATA_W,
    parameter int NARROW_W = LB_NARROW_W,
    parameter int SEL_W    = LB_SEL_W,
    parameter int OFF_W    = LB_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        postbyte_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] pc_i,
    output logic [SEL_W-1:0]  rf_sel_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic              done_o,
    output logic              taken_o,
    output logic [DATA_W-1:0] target_o,
    output logic              wb_en_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic [DATA_W-1:0] wb_data_o
);
    localparam int OP_HI    = 7;
    localparam int OP_LO    = 6;
    localparam int SENSE_B  = 5;
    localparam int SIGN_B   = 4;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              wb_en;
        logic [SEL_W-1:0]  wb_sel;
        logic [DATA_W-1:0] wb_data;
        logic [DATA_W-1:0] target;
    } res_t;

    res_t res_d, res_q;

    loop_op_e          op;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] nxt_val;
    logic [DATA_W-1:0] tgt;
    logic              cnt_zero;
    logic              sel_rsvd;
    logic              wb_ok;

    assign op       = loop_op_e'(postbyte_i[OP_HI:OP_LO]);
    assign sel      = postbyte_i[SEL_W-1:0];
    assign rf_sel_o = sel;

    loop_count_alu #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .SEL_W    (SEL_W)
    ) u_alu (
        .op_i      (op),
        .sel_i     (sel),
        .rd_data_i (rf_data_i),
        .nxt_o     (nxt_val),
        .zero_o    (cnt_zero),
        .rsvd_o    (sel_rsvd),
        .wb_ok_o   (wb_ok)
    );

    loop_target_add #(
        .ADDR_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_tgt (
        .pc_i     (pc_i),
        .sign_i   (postbyte_i[SIGN_B]),
        .off_i    (offset_i),
        .target_o (tgt)
    );

    always_comb begin
        res_d = '0;
        if (start_i) begin
            res_d.valid  = 1'b1;
            res_d.target = tgt;
            res_d.taken  = !sel_rsvd &&
                           (postbyte_i[SENSE_B] ? !cnt_zero : cnt_zero);
            if (wb_ok) begin
                res_d.wb_en   = 1'b1;
                res_d.wb_sel  = sel;
                res_d.wb_data = nxt_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o    = res_q.valid;
    assign taken_o   = res_q.taken;
    assign target_o  = res_q.target;
    assign wb_en_o   = res_q.wb_en;
    assign wb_sel_o  = res_q.wb_sel;
    assign wb_data_o = res_q.wb_data;

endmodule

// File: rtl/loop_branch_chk.sv
module loop_branch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [7:0]  postbyte_i,
    input logic [7:0]  offset_i,
    input logic [15:0] pc_i,
    input logic [2:0]  rf_sel_o,
    input logic [15:0] rf_data_i,
    input logic        done_o,
    input logic        taken_o,
    input logic [15:0] target_o,
    input logic        wb_en_o,
    input logic [2:0]  wb_sel_o,
    input logic [15:0] wb_data_o
);
    p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (done_o == $past(start_i)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!taken_o && !wb_en_o && target_o == 16'h0));

    p_test_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && postbyte_i[7:6] == 2'b01) |=> !wb_en_o);

    p_wb_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && postbyte_i[7:6] != 2'b01 && postbyte_i[2:0] != 3'd3)
        |=> (wb_en_o && wb_sel_o == $past(postbyte_i[2:0])));

    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o && wb_sel_o < 3'd3) |-> (wb_data_o[15:8] == 8'h00));

    p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (target_o == 16'($past(pc_i)
            + {{7{$past(postbyte_i[4])}}, $past(postbyte_i[4]), $past(offset_i)})));

    p_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && postbyte_i[7:6] != 2'b01 && postbyte_i[2:0] != 3'd3)
        |=> (taken_o == ($past(postbyte_i[5]) ? (wb_data_o != 16'h0)
                                              : (wb_data_o == 16'h0))));

    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && postbyte_i[2:0] == 3'd3) |=> (!taken_o && !wb_en_o));

    p_sel_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_sel_o == postbyte_i[2:0]);

endmodule

bind loop_branch_unit loop_branch_chk u_chk (.*);

// File: tb/tb_loop_branch_unit.sv
module tb_loop_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [7:0]  postbyte_i;
    logic [7:0]  offset_i;
    logic [15:0] pc_i;
    logic [2:0]  rf_sel_o;
    logic [15:0] rf_data_i;
    logic        done_o;
    logic        taken_o;
    logic [15:0] target_o;
    logic        wb_en_o;
    logic [2:0]  wb_sel_o;
    logic [15:0] wb_data_o;

    logic [15:0] regs [8];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign rf_data_i = regs[rf_sel_o];

    loop_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .postbyte_i(postbyte_i),
        .offset_i(offset_i), .pc_i(pc_i), .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
        .done_o(done_o), .taken_o(taken_o), .target_o(target_o), .wb_en_o(wb_en_o),
        .wb_sel_o(wb_sel_o), .wb_data_o(wb_data_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: one instruction in, expected outputs for the next cycle.
    task automatic step(input bit st, input int pb, input int off, input int pc,
                        input int rv, input string tag);
        int sel, op, mask, v, nv, disp;
        int e_done, e_taken, e_tgt, e_wb, e_sel, e_data;
        sel = pb & 7;
        op  = (pb >> 6) & 3;
        regs[sel] = rv[15:0];
        start_i = st; postbyte_i = pb[7:0]; offset_i = off[7:0]; pc_i = pc[15:0];
        #1;
        check(tag, "rf_sel", int'(rf_sel_o), sel);
        mask = (sel < 3) ? 255 : 65535;
        v = rv & mask;
        if (op == 1)      nv = v;
        else if (op == 2) nv = (v + 1) & mask;
        else              nv = (v + mask) & mask;
        disp = off + (((pb >> 4) & 1) != 0 ? -256 : 0);
        e_done = st; e_taken = 0; e_tgt = 0; e_wb = 0; e_sel = 0; e_data = 0;
        if (st) begin
            e_tgt = (pc + disp) & 65535;
            if (sel != 3) begin
                e_taken = ((pb >> 5) & 1) != 0 ? (nv != 0) : (nv == 0);
                if (op != 1) begin
                    e_wb = 1; e_sel = sel; e_data = nv;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "done",    int'(done_o),    e_done);
        check(tag, "taken",   int'(taken_o),   e_taken);
        check(tag, "target",  int'(target_o),  e_tgt);
        check(tag, "wb_en",   int'(wb_en_o),   e_wb);
        check(tag, "wb_sel",  int'(wb_sel_o),  e_sel);
        check(tag, "wb_data", int'(wb_data_o), e_data);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'h0;
        rst_n = 1'b0; start_i = 1'b0; postbyte_i = 8'h0; offset_i = 8'h0; pc_i = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "done",    int'(done_o), 0);
        check("R1", "wb_en",   int'(wb_en_o), 0);
        check("R1", "target",  int'(target_o), 0);
        check("R1", "wb_data", int'(wb_data_o), 0);
        rst_n = 1'b1;
        step(0, 8'h00, 0, 0, 0, "R1");
        // R3/R5: decrement D to zero, branch on zero
        step(1, 8'h04, 8'h10, 16'h2000, 16'h0001, "R3");
        // R3: decrement X from zero wraps, branch on non-zero
        step(1, 8'h25, 8'hF0, 16'h2000, 16'h0000, "R3");
        // R3: increment Y from FFFF wraps to zero
        step(1, 8'h86, 8'h04, 16'h3000, 16'hFFFF, "R3");
        // R3: op code 3 behaves as decrement
        step(1, 8'hC5, 8'h01, 16'h3000, 16'h0010, "R3");
        // R4/R9: increment A, 8-bit wrap, upper byte ignored
        step(1, 8'h80, 8'h02, 16'h4000, 16'h12FF, "R4");
        // R4: decrement CCR, branch on non-zero
        step(1, 8'h22, 8'h02, 16'h4000, 16'hAB80, "R4");
        // R8/R9: test B with zero low byte
        step(1, 8'h41, 8'h08, 16'h5000, 16'h3400, "R9");
        // R8: test SP non-zero, branch on non-zero, no writeback
        step(1, 8'h67, 8'h08, 16'h5000, 16'h0005, "R8");
        // R7: writeback when branch not taken
        step(1, 8'h04, 8'h08, 16'h5000, 16'h0005, "R7");
        // R10: reserved selector
        step(1, 8'h03, 8'h08, 16'h5000, 16'h0001, "R10");
        step(1, 8'hA3, 8'h08, 16'h5000, 16'h0000, "R10");
        // R6: negative and boundary displacements
        step(1, 8'h14, 8'h00, 16'h1000, 16'h0002, "R6");
        step(1, 8'h14, 8'hFF, 16'h1000, 16'h0002, "R6");
        step(1, 8'h04, 8'hFF, 16'hFFF0, 16'h0002, "R6");
        step(1, 8'h15, 8'h10, 16'h0004, 16'h0002, "R6");
        // R2: idle cycle between starts
        step(0, 8'h84, 8'h33, 16'h7777, 16'h0001, "R2");
        step(1, 8'h84, 8'h33, 16'h7777, 16'h0001, "R2");
        step(0, 8'h00, 8'h00, 16'h0000, 16'h0000, "R2");
        for (int n = 0; n < 400; n++) begin
            int rv;
            rv = (n % 7 == 0) ? 0 : ((n % 11 == 0) ? 1 : int'($urandom_range(0, 65535)));
            step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)), rv, "R5");
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule